// File: doc/BRIEF.md
# Domain Access Permission Checker

This block decides whether a memory access that has already been translated may go ahead. Each request carries the translation's domain number, its two access-permission bits, an extra bit that makes the page read-only, and an execute-never bit. It also carries the kind of access (data read, data write or instruction fetch) and whether the processor is in privileged mode. A 32-bit domain control word is held inside the block and loaded through a simple write port. It gives every one of the 16 domains a two-bit mode. A domain can refuse all accesses, enforce the page permissions (client), or wave every access through regardless of page bits (manager).

One cycle after a request is presented, the block returns a registered verdict. The verdict is either allow, or a fault with a code telling a domain fault apart from a permission fault. The checker is meant to sit directly behind a translation lookup. The domain mode is resolved first. The page permission bits are only consulted for client domains.

Top module: `dom_guard`

## Requirements
- R1: During and right after reset the response is idle (valid 0, allow 0, fault code 00). The domain control word resets to all zeros, so every domain starts as no-access.
- R2: A request sampled with `req_valid` high at a rising edge yields `rsp_valid` high after that same edge. Without a request, the next edge drives valid, allow and fault code to 0.
- R3: Domain n takes its mode from control-word bits [2n+1:2n]. Mode 00 (no access) gives a domain fault (fault code 01) for every access.
- R4: Mode 10 is reserved and behaves exactly like no access: a domain fault.
- R5: Mode 11 (manager) allows every access. AP, the read-only bit, execute-never and privilege have no effect.
- R6: Mode 01 (client) applies the AP code, and a violation gives a permission fault (fault code 10). The AP codes are:
  - 00: nothing is granted.
  - 01: privileged read/write only.
  - 10: privileged read/write and user read.
  - 11: read/write for everyone.
- R7: In a client domain, a set read-only bit refuses every write with a permission fault. Reads are still governed by AP alone.
- R8: In a client domain, a set execute-never bit refuses instruction fetches with a permission fault. It has no effect on data reads or writes.
- R9: A control-word write takes effect for requests from the next edge onward. A request sampled at the same edge as the write is judged with the old word.
- R10: The fault code is 00 (none), 01 (domain) or 10 (permission). A valid response has allow set exactly when the code is 00.
- R11: Access kind 00 is a read and 01 is a write. Any kind with bit 1 set is an instruction fetch, which AP checks as a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dcw_wr_en | input | 1 | Load the domain control word |
| dcw_wr_data | input | 32 | New domain control word, two bits per domain |
| req_valid | input | 1 | Access request present |
| req_domain | input | 4 | Domain number of the translation |
| req_ap | input | 2 | Access-permission code |
| req_ro | input | 1 | Read-only override bit |
| req_xn | input | 1 | Execute-never bit |
| req_kind | input | 2 | 00 read, 01 write, 1x instruction fetch |
| req_priv | input | 1 | 1 when the access is made in privileged mode |
| rsp_valid | output | 1 | Verdict present (one cycle after request) |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |

## Verification
The bench targets the reserved domain mode, which a careless decoder would treat as manager or client and so let accesses through. It checks manager domains with every page bit hostile, because a design that consulted page bits there would report spurious permission faults. It separates execute-never from data accesses and the read-only bit from reads: a mix-up would refuse plain reads or let writes through. It also writes the control word in the same cycle as a request, to catch a design that forwards the new word one cycle early. The top domain is checked to catch a wrong field offset.

// File: rtl/dom_guard_pkg.sv
package dom_guard_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        DM_NOACC   = 2'b00,
        DM_CLIENT  = 2'b01,
        DM_RSVD    = 2'b10,
        DM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_DOMAIN = 2'b01,
        FLT_PERM   = 2'b10,
        FLT_SPARE  = 2'b11
    } fault_e;

    typedef struct packed {
        logic [1:0] ap;
        logic       ro;
        logic       xn;
    } page_attr_t;

    typedef struct packed {
        logic       fetch;
        logic       write;
        logic       priv;
    } acc_t;

    typedef struct packed {
        logic   valid;
        logic   allow;
        fault_e fault;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{valid: 1'b0, allow: 1'b0, fault: FLT_NONE};

    function automatic acc_t decode_kind(input logic [1:0] kind, input logic priv);
        acc_t a;
        a.fetch = kind[1];
        a.write = (kind == 2'b01);
        a.priv  = priv;
        return a;
    endfunction

    // Grant by AP code alone; fetches are checked as reads.
    function automatic logic ap_grants(input logic [1:0] ap, input acc_t a);
        logic g;
        unique case (ap)
            2'b00:   g = 1'b0;
            2'b01:   g = a.priv;
            2'b10:   g = a.priv | ~a.write;
            default: g = 1'b1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/dom_ctrl_reg.sv
module dom_ctrl_reg #(
    parameter int          WIDTH     = 32,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

endmodule

// File: rtl/dom_mode_sel.sv
module dom_mode_sel
    import dom_guard_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int WORD_W = NUM_DOM * MODE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [DOM_W-1:0]  dom,
    output dom_mode_e         mode
);

    logic [MODE_W-1:0] fields [NUM_DOM];

    for (genvar n = 0; n < NUM_DOM; n++) begin : g_unpack
        assign fields[n] = word[n*MODE_W +: MODE_W];
    end

    assign mode = dom_mode_e'(fields[dom]);

endmodule

// File: rtl/dom_perm_eval.sv
module dom_perm_eval
    import dom_guard_pkg::*;
(
    input  dom_mode_e  mode,
    input  page_attr_t attr,
    input  acc_t       acc,
    output logic       allow,
    output fault_e     fault
);

    logic page_ok;

    always_comb begin
        page_ok = ap_grants(attr.ap, acc);
        if (acc.write && attr.ro) begin
            page_ok = 1'b0;
        end
        if (acc.fetch && attr.xn) begin
            page_ok = 1'b0;
        end
    end

    always_comb begin
        unique case (mode)
            DM_MANAGER: begin
                allow = 1'b1;
                fault = FLT_NONE;
            end
            DM_CLIENT: begin
                allow = page_ok;
                fault = page_ok ? FLT_NONE : FLT_PERM;
            end
            default: begin
                allow = 1'b0;
                fault = FLT_DOMAIN;
            end
        endcase
    end

endmodule

// File: rtl/dom_guard.sv
module dom_guard
    import dom_guard_pkg::*;
#(
    parameter int NUM_DOM  = 16,
    localparam int DOM_W   = $clog2(NUM_DOM),
    localparam int WORD_W  = NUM_DOM * MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dcw_wr_en,
    input  logic [WORD_W-1:0] dcw_wr_data,
    input  logic              req_valid,
    input  logic [DOM_W-1:0]  req_domain,
    input  logic [1:0]        req_ap,
    input  logic              req_ro,
    input  logic              req_xn,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [1:0]        rsp_fault
);

    logic [WORD_W-1:0] dacr_q;
    dom_mode_e         mode;
    page_attr_t        attr;
    acc_t              acc;
    logic              cmb_allow;
    fault_e            cmb_fault;
    verdict_t          verdict_q;

    dom_ctrl_reg #(
        .WIDTH   (WORD_W),
        .RST_VAL ('0)
    ) u_dcw (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dcw_wr_en),
        .wr_data (dcw_wr_data),
        .q       (dacr_q)
    );

    dom_mode_sel #(
        .NUM_DOM (NUM_DOM)
    ) u_sel (
        .word (dacr_q),
        .dom  (req_domain),
        .mode (mode)
    );

    assign attr = '{ap: req_ap, ro: req_ro, xn: req_xn};
    assign acc  = decode_kind(req_kind, req_priv);

    dom_perm_eval u_eval (
        .mode  (mode),
        .attr  (attr),
        .acc   (acc),
        .allow (cmb_allow),
        .fault (cmb_fault)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            verdict_q <= VERDICT_IDLE;
        end else begin
            verdict_q <= '{valid: 1'b1, allow: cmb_allow, fault: cmb_fault};
        end
    end

    assign rsp_valid = verdict_q.valid;
    assign rsp_allow = verdict_q.allow;
    assign rsp_fault = verdict_q.fault;

endmodule

// File: rtl/dom_guard_checker.sv
module dom_guard_checker #(
    parameter int NUM_DOM  = 16,
    localparam int DOM_W   = $clog2(NUM_DOM),
    localparam int WORD_W  = NUM_DOM * 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dcw_wr_en,
    input  logic [WORD_W-1:0] dcw_wr_data,
    input  logic [WORD_W-1:0] dacr_q,
    input  logic              req_valid,
    input  logic [DOM_W-1:0]  req_domain,
    input  logic              req_xn,
    input  logic [1:0]        req_kind,
    input  logic              rsp_valid,
    input  logic              rsp_allow,
    input  logic [1:0]        rsp_fault
);

    logic [1:0] fld;
    assign fld = 2'(dacr_q >> {req_domain, 1'b0});

    // R1: response idle on the cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_allow && rsp_fault == 2'b00));

    // R2: one-cycle response latency
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_allow));

    // R3/R4: no-access and reserved domains fault
    a_r3_noacc_domain_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !dcw_wr_en && fld == 2'b00) |=> rsp_fault == 2'b01);
    a_r4_rsvd_domain_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fld == 2'b10) |=> (rsp_fault == 2'b01 && !rsp_allow));

    // R5: manager always allows
    a_r5_manager_allows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fld == 2'b11) |=> rsp_allow);

    // R8: execute-never refuses fetch in a client domain
    a_r8_xn_fetch: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fld == 2'b01 && req_xn && req_kind[1]) |=> rsp_fault == 2'b10);

    // R9: written word is in place after the edge
    a_r9_word_loaded: assert property (@(posedge clk) disable iff (rst)
        dcw_wr_en |=> dacr_q == $past(dcw_wr_data));

    // R10: allow and fault code agree
    a_r10_allow_no_fault: assert property (@(posedge clk) disable iff (rst)
        rsp_allow |-> (rsp_valid && rsp_fault == 2'b00));
    a_r10_deny_has_code: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_allow) |-> (rsp_fault == 2'b01 || rsp_fault == 2'b10));

endmodule

bind dom_guard dom_guard_checker #(.NUM_DOM(NUM_DOM)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dcw_wr_en   (dcw_wr_en),
    .dcw_wr_data (dcw_wr_data),
    .dacr_q      (dacr_q),
    .req_valid   (req_valid),
    .req_domain  (req_domain),
    .req_xn      (req_xn),
    .req_kind    (req_kind),
    .rsp_valid   (rsp_valid),
    .rsp_allow   (rsp_allow),
    .rsp_fault   (rsp_fault)
);

// File: tb/dom_guard_test.sv
`timescale 1ns/1ps
module dom_guard_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        dcw_wr_en;
    logic [31:0] dcw_wr_data;
    logic        req_valid;
    logic [3:0]  req_domain;
    logic [1:0]  req_ap;
    logic        req_ro;
    logic        req_xn;
    logic [1:0]  req_kind;
    logic        req_priv;
    logic        rsp_valid;
    logic        rsp_allow;
    logic [1:0]  rsp_fault;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dom_guard uut (
        .clk         (clk),
        .rst         (rst),
        .dcw_wr_en   (dcw_wr_en),
        .dcw_wr_data (dcw_wr_data),
        .req_valid   (req_valid),
        .req_domain  (req_domain),
        .req_ap      (req_ap),
        .req_ro      (req_ro),
        .req_xn      (req_xn),
        .req_kind    (req_kind),
        .req_priv    (req_priv),
        .rsp_valid   (rsp_valid),
        .rsp_allow   (rsp_allow),
        .rsp_fault   (rsp_fault)
    );

    // Word used by the table: d0=00, d1=01, d2=10, d3=11, d4..d14=01, d15=11
    localparam logic [31:0] TABLE_WORD = 32'hD555_55E4;

    // Vector: [17:14] req, [13:10] dom, [9:8] ap, [7] ro, [6] xn,
    //         [5:4] kind, [3] priv, [2] allow, [1:0] fault
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {4'd3,  4'd0,  2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01}, // R3 no-access
        {4'd4,  4'd2,  2'b11, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 2'b01}, // R4 reserved
        {4'd5,  4'd3,  2'b00, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 2'b00}, // R5 manager write
        {4'd5,  4'd3,  2'b00, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 2'b00}, // R5 manager fetch
        {4'd6,  4'd1,  2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b10}, // R6 ap00
        {4'd6,  4'd1,  2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 2'b00}, // R6 ap01 priv rd
        {4'd6,  4'd1,  2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b10}, // R6 ap01 user rd
        {4'd6,  4'd1,  2'b01, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 2'b00}, // R6 ap01 priv wr
        {4'd6,  4'd1,  2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R6 ap10 user rd
        {4'd6,  4'd1,  2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 2'b10}, // R6 ap10 user wr
        {4'd6,  4'd1,  2'b10, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 2'b00}, // R6 ap10 priv wr
        {4'd6,  4'd1,  2'b11, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 2'b00}, // R6 ap11 user wr
        {4'd7,  4'd1,  2'b11, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b10}, // R7 ro write
        {4'd7,  4'd1,  2'b11, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R7 ro read
        {4'd7,  4'd1,  2'b01, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 2'b10}, // R7 ro priv write
        {4'd8,  4'd1,  2'b11, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 2'b10}, // R8 xn fetch
        {4'd8,  4'd1,  2'b11, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 2'b00}, // R8 xn read
        {4'd11, 4'd1,  2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 2'b00}, // R11 fetch ok
        {4'd11, 4'd1,  2'b01, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b10}, // R11 fetch as read
        {4'd3,  4'd15, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 2'b00}, // R3 top field
        {4'd8,  4'd4,  2'b11, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 2'b00}, // R8 xn write
        {4'd11, 4'd1,  2'b11, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 2'b10}  // R11 kind 11
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {valid,allow,fault} got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] rsp();
        return {rsp_valid, rsp_allow, rsp_fault};
    endfunction

    task automatic drive(input logic [3:0] dom, input logic [1:0] ap, input logic ro,
                         input logic xn, input logic [1:0] kind, input logic priv);
        req_valid  = 1'b1;
        req_domain = dom;
        req_ap     = ap;
        req_ro     = ro;
        req_xn     = xn;
        req_kind   = kind;
        req_priv   = priv;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        rst = 1'b1; dcw_wr_en = 1'b0; dcw_wr_data = '0;
        req_valid = 1'b0; req_domain = '0; req_ap = '0; req_ro = 1'b0;
        req_xn = 1'b0; req_kind = '0; req_priv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset idle", rsp(), 4'b0000);
        rst = 1'b0;

        // R1: control word reset to zero, manager-like request must domain fault
        drive(4'd3, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
        @(negedge clk);
        chk("R1 reset word no-access", rsp(), 4'b1001);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle clears", rsp(), 4'b0000);

        // load table word
        dcw_wr_en = 1'b1; dcw_wr_data = TABLE_WORD;
        @(negedge clk);
        dcw_wr_en = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            drive(v[13:10], v[9:8], v[7], v[6], v[5:4], v[3]);
            @(negedge clk);
            chk($sformatf("R%0d vec %0d", v[17:14], i), rsp(), {1'b1, v[2], v[1:0]});
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle after table", rsp(), 4'b0000);

        // R9: write d0 to manager in the same cycle as a d0 request
        dcw_wr_en = 1'b1; dcw_wr_data = TABLE_WORD | 32'h0000_0003;
        drive(4'd0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0);
        @(negedge clk);
        dcw_wr_en = 1'b0;
        chk("R9 same-cycle uses old word", rsp(), 4'b1001);
        @(negedge clk);
        chk("R9 next cycle uses new word", rsp(), 4'b1100);

        // R4: turn d3 from manager to reserved
        dcw_wr_en = 1'b1; dcw_wr_data = (TABLE_WORD & ~32'h0000_00C0) | 32'h0000_0080;
        req_valid = 1'b0;
        @(negedge clk);
        dcw_wr_en = 1'b0;
        drive(4'd3, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
        @(negedge clk);
        chk("R4 reserved after rewrite", rsp(), 4'b1001);

        // R1: mid-run reset clears word and response
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset during request", rsp(), 4'b0000);
        rst = 1'b0;
        drive(4'd15, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
        @(negedge clk);
        chk("R1 word cleared by reset", rsp(), 4'b1001);
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule